// File: doc/BRIEF.md
# Staggered Two-Channel Sync Pulse Sequencer

This block turns one synchronisation request from a host controller into a short train of sync strobes, one per satellite sensor channel. The channels fire one after another, never together. Spreading the strobes in time lowers the peak in-rush current drawn by the sensors and reduces emissions compared with firing every channel at once. The block runs in a synchronous parallel bus arrangement, where up to three sensors share each channel. Those sensors answer each strobe with one to three messages at 125 kbit/s, and the host normally requests a sync every 500 µs.

The request pin is asynchronous to the block clock. It passes through a two-flop synchroniser, and a sequence starts only on a low-to-high transition. The strobe width (`PULSE_CYC`) and the quiet gap between strobes (`GAP_CYC`, at least 1) are counted in clock cycles. A per-channel enable suppresses the strobe of that channel and leaves its time slot in place, so the timing of the other channel does not move. The strobes feed the analog pulse drivers. Pulse shaping and sensor data reception happen outside this block.

Top module: `sync_stagger_seq`

## Requirements
- R1: While and directly after synchronous reset, `ch_pulse_o` and `busy_o` are all zero.
- R2: After `sync_req_i` is first sampled high by a clock edge, `busy_o` and the channel 0 strobe (if enabled) rise on the third rising clock edge, counting that edge as the first.
- R3: Only a low-to-high transition of `sync_req_i` starts a sequence. Holding the pin high, or taking it low, starts nothing.
- R4: Each strobe issued on `ch_pulse_o` stays high for exactly `PULSE_CYC` consecutive cycles.
- R5: Strobes follow ascending channel order: bit 0 first, then bit 1. Exactly `GAP_CYC` low cycles separate the end of one slot from the start of the next, and at most one bit of `ch_pulse_o` is high in any cycle.
- R6: `busy_o` is high for exactly `NUM_CH*PULSE_CYC + (NUM_CH-1)*GAP_CYC` cycles, beginning with the first slot and falling together with the end of the last slot. It is high whenever any strobe is high.
- R7: A rising edge on `sync_req_i` detected while `busy_o` is high is dropped. No second sequence follows it.
- R8: A channel whose `ch_en_i` bit is 0 when its slot begins stays low for that slot. Slot positions, the other channel's strobe and `busy_o` are unchanged.
- R9: A new rising edge detected after `busy_o` has fallen starts a full new sequence, even if the request pin was low for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req_i | input | 1 | Asynchronous sync request from the host controller |
| ch_en_i | input | NUM_CH | Per-channel strobe enable, bit n for channel n |
| ch_pulse_o | output | NUM_CH | Registered sync strobe per channel |
| busy_o | output | 1 | Registered, high while a strobe sequence runs |

## Verification
The embedded assertions check the following on every cycle:
- at most one strobe is active at a time, and no strobe is active while a gap is running;
- every strobe has the full width;
- a strobe never appears without `busy_o`;
- a detected edge never repeats on a held level;
- a sequence only begins after a detected edge.

Only the bench scenarios can show the following:
- the exact three-edge latency through the synchroniser;
- the absolute slot positions and gap lengths;
- that an edge during a busy period and a held or falling level produce nothing afterwards;
- that a disabled channel leaves its neighbour's timing untouched.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sseq_edge_detect.sv
module sseq_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~prev;

  // a held level yields a single detection cycle
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sseq_slot_fsm.sv
module sseq_slot_fsm
  import sync_seq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned PULSE_CYC = 8,
  parameter int unsigned GAP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] pulse_o,
  output logic              busy_o
);

  localparam int unsigned CNT_W      = $clog2(max_of(PULSE_CYC, GAP_CYC) + 1);
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);
  localparam logic [CH_W-1:0]  CH_LAST    = CH_W'(NUM_CH - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  ch;
  logic [CH_W-1:0]  next_ch;

  assign next_ch = ch + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ch      <= '0;
      pulse_o <= '0;
      busy_o  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state   <= ST_PULSE;
            cnt     <= '0;
            ch      <= '0;
            busy_o  <= 1'b1;
            pulse_o <= en_i[0] ? NUM_CH'(1) : '0;
          end
        end
        ST_PULSE: begin
          if (cnt == PULSE_LAST) begin
            cnt     <= '0;
            pulse_o <= '0;
            if (ch == CH_LAST) begin
              state  <= ST_IDLE;
              busy_o <= 1'b0;
            end else begin
              state <= ST_GAP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == GAP_LAST) begin
            cnt     <= '0;
            ch      <= next_ch;
            state   <= ST_PULSE;
            pulse_o <= en_i[next_ch] ? (NUM_CH'(1) << next_ch) : '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          pulse_o <= '0;
          busy_o  <= 1'b0;
        end
      endcase
    end
  end

  // ---------------- checks ----------------
  logic [CNT_W:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)          hi_run <= '0;
    else if (|pulse_o) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;
  end

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    (hi_run != '0 && !(|pulse_o)) |-> (hi_run == (CNT_W+1)'(PULSE_CYC)));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse_o));

  assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (pulse_o == '0));

  assert_busy_covers_R6: assert property (@(posedge clk) disable iff (rst)
    (|pulse_o) |-> busy_o);

  assert_start_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/sync_stagger_seq.sv
module sync_stagger_seq #(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned PULSE_CYC   = 8,
  parameter int unsigned GAP_CYC     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_req_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  output logic [NUM_CH-1:0] ch_pulse_o,
  output logic              busy_o
);

  logic req_rise;

  sseq_edge_detect #(
    .STAGES(SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .async_i(sync_req_i),
    .rise_o (req_rise)
  );

  sseq_slot_fsm #(
    .NUM_CH   (NUM_CH),
    .PULSE_CYC(PULSE_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start_i(req_rise),
    .en_i   (ch_en_i),
    .pulse_o(ch_pulse_o),
    .busy_o (busy_o)
  );

endmodule

// File: tb/sync_stagger_seq_test.sv
module sync_stagger_seq_test;

  localparam int NCH = 2;
  localparam int P   = 8;
  localparam int G   = 4;
  localparam int L   = NCH*P + (NCH-1)*G;

  logic           clk = 1'b0;
  logic           rst;
  logic           sync_req;
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] ch_pulse;
  logic           busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  sync_stagger_seq #(.NUM_CH(NCH), .PULSE_CYC(P), .GAP_CYC(G), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .sync_req_i(sync_req), .ch_en_i(ch_en),
    .ch_pulse_o(ch_pulse), .busy_o(busy)
  );

  task automatic check(input string tag, input logic [NCH:0] act, input logic [NCH:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {busy,pulse} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected {busy,pulse} k cycles after the first slot starts
  function automatic logic [NCH:0] expect_at(input int k, input logic [NCH-1:0] en);
    logic [NCH:0] e;
    e = '0;
    if (k >= 0 && k < L) e[NCH] = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (en[c] && k >= c*(P+G) && k < c*(P+G)+P) e[c] = 1'b1;
    end
    return e;
  endfunction

  task automatic idle_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, {busy, ch_pulse}, '0);
    end
  endtask

  // raise request at a negedge and check every cycle of the sequence
  task automatic play(input logic [NCH-1:0] en, input bit glitch, input bit release_req,
                      input string tag);
    @(negedge clk);
    ch_en    = en;
    sync_req = 1'b1;
    for (int j = 1; j <= L + 11; j++) begin
      int k;
      @(negedge clk);
      k = j - 3;
      check((k < 0) ? "R2 latency" : tag, {busy, ch_pulse}, expect_at(k, en));
      if (glitch && k == 2) sync_req = 1'b0;
      if (glitch && k == 6) sync_req = 1'b1;
    end
    if (release_req) begin
      sync_req = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; sync_req = 1'b0; ch_en = '1;
    repeat (4) @(negedge clk);
    check("R1 in reset", {busy, ch_pulse}, '0);
    rst = 1'b0;
    idle_check(3, "R1 after reset");
  endtask

  task automatic t_basic();
    play(2'b11, 1'b0, 1'b1, "R4 R5 R6 both channels");
  endtask

  task automatic t_level();
    play(2'b11, 1'b0, 1'b0, "R2 R5 level start");
    idle_check(30, "R3 held high");
    sync_req = 1'b0;
    idle_check(10, "R3 falling edge");
  endtask

  task automatic t_busy_ignore();
    play(2'b11, 1'b1, 1'b1, "R7 edge while busy");
    idle_check(8, "R7 no second sequence");
  endtask

  task automatic t_skip();
    play(2'b01, 1'b0, 1'b1, "R8 channel 1 disabled");
    play(2'b10, 1'b0, 1'b1, "R8 channel 0 disabled");
    play(2'b00, 1'b0, 1'b1, "R8 both disabled");
  endtask

  task automatic t_back2back();
    play(2'b11, 1'b0, 1'b0, "R9 first");
    @(negedge clk); sync_req = 1'b0;
    play(2'b11, 1'b0, 1'b1, "R9 restart after one low cycle");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_level();
    t_busy_ignore();
    t_skip();
    t_back2back();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule